// File: doc/BRIEF.md
# DDC serial clock divider

This block derives the timing reference for a display data channel (I2C-style) controller from its parent clock. The parent clock passes through four divide stages. The first is a fixed pre-divider. The second is a fixed divide-by-ten. The third divides by 2^N. The fourth divides by (M + M offset). The pre-divider and the M offset are elaboration parameters, so one RTL serves both controller variants. One variant runs from the fast shared clock, with a pre-divider of 2 and an offset of 1. The other variant runs from a slower dedicated clock, with no pre-division and its own offset. Software normally programs N and M so that the serial clock lands near 100 kHz.

N and M are packed into one 7-bit field. Software writes the field and reads it back. A write restarts every internal counter, so the first output period after a change is always a full one. The block gives two outputs. The first is a one-cycle tick at twice the serial clock rate, which paces the half-bit steps of the transfer engine. The second is a serial clock reference that toggles on every tick.

The enable input gates the whole chain. The transfer logic downstream must not run until this divider is enabled and ticking.

Top module: `ddc_clk_div`

## Requirements
- R1: While reset is asserted and on release, `tick_o` and `scl_o` are 0 and `cfg_rdata_o` is 0 (N = 0, M = 0).
- R2: A write on `cfg_we_i` stores `cfg_wdata_i`. N is in bits [2:0] and M is in bits [6:3]. The stored value appears on `cfg_rdata_o` in the cycle after the write edge.
- R3: While enabled, ticks are spaced by exactly T = PRE_DIV * 5 * 2^N * L parent cycles. The serial clock period is therefore PRE_DIV * 10 * 2^N * L parent cycles.
- R4: `tick_o` is high for exactly one parent cycle per tick.
- R5: `scl_o` inverts on each tick and holds its value between ticks. It is high after an odd number of ticks since the last restart.
- R6: The linear factor L is M + M_OFFSET. When that sum is 0, L is taken as 1.
- R7: A write clears `tick_o` and `scl_o` in the following cycle. The first tick after the write comes T cycles after the write edge.
- R8: While `en_i` is low, there are no ticks and `scl_o` is 0. After `en_i` rises, the first tick comes T cycles later, counting the first edge on which `en_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Divider run enable |
| cfg_we_i | input | 1 | Divider field write strobe |
| cfg_wdata_i | input | 7 | New field value: M in [6:3], N in [2:0] |
| cfg_rdata_o | output | 7 | Current field value |
| tick_o | output | 1 | One-cycle pulse per half serial clock period |
| scl_o | output | 1 | Serial clock reference, toggles per tick |

## Verification
A counter that drifts, or a wrong modulus in any stage, shows up as a tick spacing other than T. It appears in the first interval after a restart, at most one full period in. A missed restart on a write or on an enable shows up as a first tick earlier than T, or as `scl_o` left high. Both are visible within one cycle or one period. A wrong field split between N and M shows up as a period off by a power of two or by a linear factor. The bench therefore programs mixed random M and N values on both variants, plus the extreme field values.

// File: rtl/ddc_div_pkg.sv
package ddc_div_pkg;
  localparam int FIELD_W = 7;
  localparam int N_W     = 3;
  localparam int M_W     = 4;
  localparam int POW_W   = (1 << N_W) - 1;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } div_cfg_t;

  // last count of the 2^N stage
  function automatic logic [POW_W-1:0] pow_last(input logic [N_W-1:0] n);
    logic [POW_W:0] v;
    v = (POW_W+1)'(1) << n;
    return POW_W'(v - 1'b1);
  endfunction
endpackage

// File: rtl/ddc_div_cfg_reg.sv
module ddc_div_cfg_reg
  import ddc_div_pkg::*;
#(
  parameter int M_OFFSET = 1,
  localparam int LW = ($clog2(15 + M_OFFSET) < 1) ? 1 : $clog2(15 + M_OFFSET)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [FIELD_W-1:0] wdata_i,
  output logic [FIELD_W-1:0] rdata_o,
  output logic [POW_W-1:0]   pow_last_o,
  output logic [LW-1:0]      lin_last_o
);
  div_cfg_t cfg_q;
  logic [LW:0] lin_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= div_cfg_t'(wdata_i);
  end

  assign rdata_o    = cfg_q;
  assign pow_last_o = pow_last(cfg_q.n);

  always_comb begin
    lin_sum = (LW+1)'(cfg_q.m) + (LW+1)'(M_OFFSET);
    // zero divisor is treated as one
    if (lin_sum == '0) lin_last_o = '0;
    else               lin_last_o = LW'(lin_sum - 1'b1);
  end

  // R2
  readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o == $past(wdata_i));
endmodule

// File: rtl/ddc_div_stage.sv
module ddc_div_stage #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] last_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = adv_i && !clr_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_q + 1'b1;
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);
endmodule

// File: rtl/ddc_clk_div.sv
module ddc_clk_div
  import ddc_div_pkg::*;
#(
  parameter int PRE_DIV  = 2,
  parameter int M_OFFSET = 1,
  localparam int P0     = PRE_DIV * 5,
  localparam int P0W    = ($clog2(P0) < 1) ? 1 : $clog2(P0),
  localparam int LW     = ($clog2(15 + M_OFFSET) < 1) ? 1 : $clog2(15 + M_OFFSET)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               cfg_we_i,
  input  logic [FIELD_W-1:0] cfg_wdata_i,
  output logic [FIELD_W-1:0] cfg_rdata_o,
  output logic               tick_o,
  output logic               scl_o
);
  logic [POW_W-1:0] pow_last;
  logic [LW-1:0]    lin_last;
  logic             restart;
  logic             wrap0, wrap1, wrap2;
  logic             tick_q, scl_q;

  assign restart = cfg_we_i || !en_i;

  ddc_div_cfg_reg #(.M_OFFSET(M_OFFSET)) u_cfg (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .rdata_o   (cfg_rdata_o),
    .pow_last_o(pow_last),
    .lin_last_o(lin_last)
  );

  // pre-divider merged with the half of the /10 stage
  ddc_div_stage #(.W(P0W)) u_pre (
    .clk_i, .rst_ni, .clr_i(restart), .adv_i(en_i),
    .last_i(P0W'(P0 - 1)), .wrap_o(wrap0)
  );

  ddc_div_stage #(.W(POW_W)) u_pow (
    .clk_i, .rst_ni, .clr_i(restart), .adv_i(wrap0),
    .last_i(pow_last), .wrap_o(wrap1)
  );

  ddc_div_stage #(.W(LW)) u_lin (
    .clk_i, .rst_ni, .clr_i(restart), .adv_i(wrap1),
    .last_i(lin_last), .wrap_o(wrap2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      scl_q  <= 1'b0;
    end else if (restart) begin
      tick_q <= 1'b0;
      scl_q  <= 1'b0;
    end else begin
      tick_q <= wrap2;
      if (wrap2) scl_q <= !scl_q;
    end
  end

  assign tick_o = tick_q;
  assign scl_o  = scl_q;

  // R4
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  // R5
  scl_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> scl_o != $past(scl_o));
  // R5
  scl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !$past(restart)) |-> $stable(scl_o));
  // R7
  write_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (!tick_o && !scl_o));
  // R8
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!tick_o && !scl_o));
endmodule

// File: tb/tb_ddc_clk_div.sv
`timescale 1ns/1ps
module tb_ddc_clk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       we [2];
  logic [6:0] wdata [2];
  logic [6:0] rdata [2];
  logic       tick [2];
  logic       scl [2];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ddc_clk_div #(.PRE_DIV(2), .M_OFFSET(1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cfg_we_i(we[0]),
    .cfg_wdata_i(wdata[0]), .cfg_rdata_o(rdata[0]), .tick_o(tick[0]), .scl_o(scl[0])
  );
  ddc_clk_div #(.PRE_DIV(1), .M_OFFSET(0)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cfg_we_i(we[1]),
    .cfg_wdata_i(wdata[1]), .cfg_rdata_o(rdata[1]), .tick_o(tick[1]), .scl_o(scl[1])
  );

  function automatic int exp_t(int idx, logic [6:0] f);
    int pre, off, l;
    pre = (idx == 0) ? 2 : 1;
    off = (idx == 0) ? 1 : 0;
    l = int'(f[6:3]) + off;
    if (l == 0) l = 1;
    return pre * 5 * (1 << f[2:0]) * l;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // cycles until next tick, sampled after each edge
  task automatic wait_tick(int idx, int lim, output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!tick[idx] && n < lim);
  endtask

  task automatic prog(int idx, logic [6:0] v);
    int t, n;
    t = exp_t(idx, v);
    @(negedge clk);
    we[idx] = 1'b1; wdata[idx] = v;
    @(posedge clk); #1;
    we[idx] = 1'b0;
    chk(rdata[idx] == v, "R2 readback", int'(rdata[idx]), int'(v));
    chk(!tick[idx] && !scl[idx], "R7 cleared on write", int'({tick[idx], scl[idx]}), 0);
    wait_tick(idx, 4 * t + 10, n);
    chk(n == t, "R7 R6 first period", n, t);
    chk(scl[idx] == 1'b1, "R5 scl high after first tick", int'(scl[idx]), 1);
    @(posedge clk); #1;
    chk(!tick[idx], "R4 tick width", int'(tick[idx]), 0);
    wait_tick(idx, 4 * t + 10, n);
    chk(n + 1 == t, "R3 steady period", n + 1, t);
    chk(scl[idx] == 1'b0, "R5 scl low after second tick", int'(scl[idx]), 0);
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, t;
    logic [6:0] v;
    void'($urandom(32'd1234));
    we[0] = 0; we[1] = 0; wdata[0] = '0; wdata[1] = '0;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < 2; i++) begin
      chk(!tick[i] && !scl[i] && rdata[i] == 0, "R1 reset state",
          int'({tick[i], scl[i], rdata[i]}), 0);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(rdata[0] == 0 && !tick[0], "R1 after release", int'(rdata[0]), 0);

    // R8: disabled, no ticks
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      if (tick[0] || scl[0] || tick[1] || scl[1])
        chk(0, "R8 idle while disabled", 1, 0);
    end
    total++;
    @(negedge clk); en = 1'b1;
    wait_tick(0, 100, n);
    chk(n == exp_t(0, 7'd0), "R8 R3 first tick after enable", n, exp_t(0, 7'd0));

    // directed corners
    prog(0, 7'h00);
    prog(0, 7'h7f);
    prog(0, 7'b0001_011);
    prog(1, 7'h00);   // L = 0 -> 1 (R6)
    prog(1, 7'b1000_000);
    prog(1, 7'h7f);

    // random
    for (int k = 0; k < 16; k++) begin
      v = 7'($urandom);
      v[2:0] = 3'($urandom_range(0, 3));
      prog(k % 2, v);
    end

    // disable mid-run then re-enable with a non-default field
    prog(0, 7'b0010_001);
    @(negedge clk); en = 1'b0;
    @(posedge clk); #1;
    chk(!tick[0] && !scl[0], "R8 disable clears", int'({tick[0], scl[0]}), 0);
    t = exp_t(0, 7'b0010_001);
    for (int k = 0; k < 2 * t; k++) begin
      @(posedge clk); #1;
      if (tick[0]) chk(0, "R8 no tick while disabled", 1, 0);
    end
    total++;
    @(negedge clk); en = 1'b1;
    wait_tick(0, 4 * t, n);
    chk(n == t, "R8 re-enable period", n, t);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule